// File: doc/BRIEF.md
# Packed SIMD Saturating Subtractor

This block subtracts one packed vector from another lane by lane and clamps every lane result that falls outside the range of its lane type. The lane width (8, 16, 32 or 64 bits) and the arithmetic (signed or unsigned) are chosen per operation. All of them run on one shared datapath, so a vector unit can issue any mix of element types back to back.

A length select processes either the full 128-bit vector or only its low 64 bits. In the short form the upper half of the result is zero. The result and a valid strobe come out one clock after a valid input. A sticky flag records whether any active lane has clamped since it was last cleared. Software clears the flag through a dedicated input.

Top module: `simd_qsub`

## Requirements
- R1: `elem_size_i` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 16-bit, 2'b10 32-bit and 2'b11 64-bit. Each result lane is the first-operand lane minus the second-operand lane, and no borrow crosses a lane boundary.
- R2: With `unsigned_i`=0, a lane whose true difference exceeds 2^(n-1)-1 yields 2^(n-1)-1, where n is the lane width.
- R3: With `unsigned_i`=0, a lane whose true difference is below -2^(n-1) yields -2^(n-1), which is a 1 followed by zeros.
- R4: With `unsigned_i`=1, a lane whose second operand is larger than its first yields 0. Other unsigned lanes yield the exact difference.
- R5: With `quad_i`=0, only bits 63:0 are processed. Result bits 127:64 are zero, and lanes in the upper half never set the saturation flag.
- R6: `sat_o` becomes 1 in the cycle after a valid operation in which any active lane clamped.
- R7: `sat_o` is sticky. Later operations that do not clamp leave it at 1, and only `sat_clr_i` or reset return it to 0. A clamping operation in the same cycle as `sat_clr_i` leaves it at 1.
- R8: `result_o` and `valid_o` are registered. They update one clock after `valid_i`, `valid_o` follows `valid_i` with one cycle of delay, and `result_o` holds its value while `valid_i` is low.
- R9: After reset, `result_o` is 0, `sat_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| elem_size_i | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=64) |
| unsigned_i | input | 1 | 1: unsigned lanes, 0: signed lanes |
| quad_i | input | 1 | 1: full 128-bit vector, 0: low 64 bits only |
| op_a_i | input | 128 | Minuend vector |
| op_b_i | input | 128 | Subtrahend vector |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| valid_o | output | 1 | Result registered this cycle |
| result_o | output | 128 | Saturated difference vector |
| sat_o | output | 1 | Sticky cumulative saturation flag |

## Verification
The bench drives both clamping directions at every lane width. It checks that a positive overflow gives the maximum and a negative one gives the minimum; a design that swapped them, or let the difference wrap, would give the wrong sign. Lanes where a borrow would ripple into a neighbour are exercised, and a datapath that did not cut the carry chain at the chosen width would corrupt the adjacent lane. Short-vector operations carry clamping values in the upper half, so a design that failed to mask those lanes would leave nonzero high bits or raise the flag falsely. The bench also clears the flag during a clamping operation and issues idle cycles, which catches a flag that loses a saturation event or a result register that updates without a valid input.

// File: rtl/simd_qsub_pkg.sv
package simd_qsub_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } elem_size_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MIN_LANE_W = 8;
endpackage

// File: rtl/qsub_lane.sv
module qsub_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         unsigned_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  logic [W:0]   wide;
  logic [W-1:0] diff;
  logic         borrow;
  logic         s_ovf;

  assign wide   = {1'b0, a_i} - {1'b0, b_i};
  assign diff   = wide[W-1:0];
  assign borrow = wide[W];
  // signed overflow: operand signs differ and result sign departs from minuend
  assign s_ovf  = (a_i[W-1] ^ b_i[W-1]) & (diff[W-1] ^ a_i[W-1]);

  always_comb begin
    if (unsigned_i) begin
      res_o = borrow ? '0 : diff;
      sat_o = borrow;
    end else begin
      sat_o = s_ovf;
      if (!s_ovf)        res_o = diff;
      else if (a_i[W-1]) res_o = {1'b1, {(W-1){1'b0}}};
      else               res_o = {1'b0, {(W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/qsub_group.sv
module qsub_group #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned W     = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             unsigned_i,
  input  logic             quad_i,
  output logic [VEC_W-1:0] res_o,
  output logic             sat_o
);
  localparam int unsigned LANES      = VEC_W / W;
  localparam int unsigned HALF_LANES = LANES / 2;

  logic [LANES-1:0] sat_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] l_res;
    logic         l_sat;
    logic         l_en;

    if (i < HALF_LANES) begin : g_low
      assign l_en = 1'b1;
    end else begin : g_high
      assign l_en = quad_i;
    end

    qsub_lane #(.W(W)) i_lane (
      .a_i       (a_i[i*W +: W]),
      .b_i       (b_i[i*W +: W]),
      .unsigned_i(unsigned_i),
      .res_o     (l_res),
      .sat_o     (l_sat)
    );

    assign res_o[i*W +: W] = l_en ? l_res : '0;
    assign sat_vec[i]      = l_en & l_sat;
  end

  assign sat_o = |sat_vec;
endmodule

// File: rtl/simd_qsub.sv
module simd_qsub
  import simd_qsub_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       elem_size_i,
  input  logic             unsigned_i,
  input  logic             quad_i,
  input  logic [VEC_W-1:0] op_a_i,
  input  logic [VEC_W-1:0] op_b_i,
  input  logic             sat_clr_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o,
  output logic             sat_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] grp_res [NUM_SIZES];
  logic             grp_sat [NUM_SIZES];
  logic [VEC_W-1:0] sel_res;
  logic             sel_sat;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    qsub_group #(.VEC_W(VEC_W), .W(MIN_LANE_W << k)) i_group (
      .a_i       (op_a_i),
      .b_i       (op_b_i),
      .unsigned_i(unsigned_i),
      .quad_i    (quad_i),
      .res_o     (grp_res[k]),
      .sat_o     (grp_sat[k])
    );
  end

  always_comb begin
    unique case (elem_size_e'(elem_size_i))
      ESZ_8:   begin sel_res = grp_res[0]; sel_sat = grp_sat[0]; end
      ESZ_16:  begin sel_res = grp_res[1]; sel_sat = grp_sat[1]; end
      ESZ_32:  begin sel_res = grp_res[2]; sel_sat = grp_sat[2]; end
      default: begin sel_res = grp_res[3]; sel_sat = grp_sat[3]; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      sat_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= sel_res;
      // a clamp in the clearing cycle survives the clear
      sat_o <= (sat_o & ~sat_clr_i) | (valid_i & sel_sat);
    end
  end

  assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !quad_i) |=> (result_o[VEC_W-1:HALF_W] == '0));
  assert_sat_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o) |-> $past(valid_i));
  assert_sat_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !sat_clr_i) |=> sat_o);
  assert_unsigned_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unsigned_i && elem_size_i == 2'b00 && op_a_i[7:0] < op_b_i[7:0])
      |=> (result_o[7:0] == 8'h00 && sat_o));
endmodule

// File: tb/test_simd_qsub.sv
`timescale 1ns/1ps
module test_simd_qsub;
  localparam int VEC_W = 128;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic [1:0]       size_i = 2'b00;
  logic             uns_i = 1'b0;
  logic             quad_i = 1'b1;
  logic [VEC_W-1:0] a_i = '0;
  logic [VEC_W-1:0] b_i = '0;
  logic             clr_i = 1'b0;
  logic             valid_o;
  logic [VEC_W-1:0] result_o;
  logic             sat_o;

  int n_run = 0;
  int n_fail = 0;
  logic [VEC_W-1:0] exp_res = '0;
  logic             exp_sat = 1'b0;
  logic             exp_valid = 1'b0;

  always #2.5 clk = ~clk;

  simd_qsub #(.VEC_W(VEC_W)) i_simd_qsub (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .elem_size_i(size_i),
    .unsigned_i(uns_i), .quad_i(quad_i), .op_a_i(a_i), .op_b_i(b_i),
    .sat_clr_i(clr_i), .valid_o(valid_o), .result_o(result_o), .sat_o(sat_o)
  );

  function automatic logic [127:0] ref_sub(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz, input logic uns,
                                           input logic quad, output logic sat);
    int w = 8 << sz;
    int lanes = (quad ? 128 : 64) / w;
    logic [63:0] mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    logic [127:0] res = '0;
    sat = 1'b0;
    for (int i = 0; i < lanes; i++) begin
      logic [127:0] sa = a >> (i * w);
      logic [127:0] sb = b >> (i * w);
      logic [63:0] la = sa[63:0] & mask;
      logic [63:0] lb = sb[63:0] & mask;
      logic signed [66:0] ea, eb, d, mx, mn;
      logic [63:0] r;
      logic [127:0] r_wide;
      ea = (!uns && la[w-1]) ? {3'b111, la | ~mask} : {3'b000, la};
      eb = (!uns && lb[w-1]) ? {3'b111, lb | ~mask} : {3'b000, lb};
      d  = ea - eb;
      mx = uns ? {3'b000, mask} : {3'b000, mask >> 1};
      mn = uns ? 67'sd0 : -mx - 67'sd1;
      if (d > mx) begin r = mx[63:0]; sat = 1'b1; end
      else if (d < mn) begin r = mn[63:0]; sat = 1'b1; end
      else r = d[63:0];
      r_wide = {64'd0, r & mask};
      res = res | (r_wide << (i * w));
    end
    return res;
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (result_o !== exp_res || sat_o !== exp_sat || valid_o !== exp_valid) begin
      n_fail++;
      $display("FAIL %s: res=%h sat=%b valid=%b expected res=%h sat=%b valid=%b",
               tag, result_o, sat_o, valid_o, exp_res, exp_sat, exp_valid);
    end
  endtask

  task automatic op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                    input logic uns, input logic quad, input logic clr, input string tag);
    logic s;
    logic [127:0] r;
    @(negedge clk);
    valid_i = 1'b1; a_i = a; b_i = b; size_i = sz; uns_i = uns; quad_i = quad; clr_i = clr;
    r = ref_sub(a, b, sz, uns, quad, s);
    exp_res = r;
    exp_sat = (clr ? 1'b0 : exp_sat) | s;
    exp_valid = 1'b1;
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic idle(input logic clr, input string tag);
    @(negedge clk);
    valid_i = 1'b0; clr_i = clr;
    a_i = {4{32'hdead_beef}}; b_i = {4{32'h1234_5678}};
    exp_sat = clr ? 1'b0 : exp_sat;
    exp_valid = 1'b0;
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R9");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R9");

    // R1: exact differences at each width, borrow must not cross lanes
    op({16{8'h10}}, {16{8'h11}}, 2'b01, 1'b0, 1'b1, 1'b0, "R1");
    op({8{16'h0100}}, {8{16'h0001}}, 2'b00, 1'b0, 1'b1, 1'b0, "R1");
    op({4{32'h0001_0000}}, {4{32'h0000_0001}}, 2'b10, 1'b1, 1'b1, 1'b0, "R1");
    op({2{64'h1_0000_0000}}, {2{64'h1}}, 2'b11, 1'b0, 1'b1, 1'b0, "R1");
    idle(1'b1, "R8");

    // R2 / R3 signed clamps at every width
    for (int s = 0; s < 4; s++) begin
      int w = 8 << s;
      logic [127:0] maxp = '0, minn = '0, m1 = '0, one = '0;
      for (int i = 0; i < 128 / w; i++) begin
        for (int k = 0; k < w; k++) begin
          maxp[i*w+k] = (k != w - 1);
          minn[i*w+k] = (k == w - 1);
          m1[i*w+k]   = 1'b1;
          one[i*w+k]  = (k == 0);
        end
      end
      op(maxp, m1, s[1:0], 1'b0, 1'b1, 1'b0, "R2");
      idle(1'b1, "R7");
      op(minn, one, s[1:0], 1'b0, 1'b1, 1'b0, "R3");
      op(minn, m1, s[1:0], 1'b0, 1'b1, 1'b1, "R7");
      op({4{32'h0}}, one, s[1:0], 1'b1, 1'b1, 1'b0, "R4");
      op(one, one, s[1:0], 1'b1, 1'b1, 1'b1, "R4");
    end

    // R5: upper half saturating, short vector must ignore it
    idle(1'b1, "R7");
    op({64'h8000_0000_0000_0000, 64'h5}, {64'h1, 64'h3}, 2'b11, 1'b0, 1'b0, 1'b0, "R5");
    op({{8{8'h00}}, {8{8'h40}}}, {{8{8'h01}}, {8{8'h20}}}, 2'b00, 1'b1, 1'b0, 1'b0, "R5");
    op({{8{8'h00}}, {7{8'h40}}, 8'h00}, {{8{8'h01}}, {8{8'h20}}}, 2'b00, 1'b1, 1'b0, 1'b0, "R6");
    op({4{32'h5}}, {4{32'h1}}, 2'b10, 1'b0, 1'b1, 1'b0, "R7");
    idle(1'b0, "R8");
    idle(1'b0, "R7");
    idle(1'b1, "R7");
    op({4{32'h9}}, {4{32'h1}}, 2'b10, 1'b1, 1'b1, 1'b0, "R6");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [127:0] ra = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] rb = {$urandom, $urandom, $urandom, $urandom};
      logic [3:0] ctl = 4'($urandom);
      if (n % 7 == 3) idle(ctl[0], "R8");
      else op(ra, rb, ctl[1:0], ctl[2], ctl[3], (n % 11 == 0), "R1");
    end

    @(negedge clk) valid_i = 1'b0; clr_i = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule